// File: doc/BRIEF.md
# Fully Associative Byte-Read Cache with First-In-First-Out Replacement

This block keeps a small number of 32-bit memory blocks close to a requester. It has no index field. A 24-bit byte address splits into a 22-bit tag and a 2-bit byte offset. The tag of every resident line is compared with the request tag at the same time, so a block may sit in any line. A read that hits returns the addressed byte combinationally, in the cycle the request is presented.

A read that misses stalls the requester. The block then asks memory for the whole 32-bit block. When the block arrives, the block forwards the wanted byte and installs the block in a line. An empty line is used first, taking the lowest-numbered one. When every line is full, the line that has been resident the longest is overwritten, chosen by a wrap-around pointer.

Writes pass straight through to memory in the cycle they are accepted. A write also patches the cached copy if the block is present. A write that misses allocates nothing.

Top module: `fac_cache`

## Requirements
- R1: After reset `reqReady` is 1, `respValid` and `memReqValid` are 0, and every line is empty, so the first read of any address misses.
- R2: A read presented while `reqReady` is 1 whose tag matches a resident line gives `respValid`=1 and `respHit`=1 in that same cycle, with `memReqValid` held at 0.
- R3: The returned byte is chosen by the offset, little-endian: offset 0 gives block bits 7:0, 1 gives 15:8, 2 gives 23:16 and 3 gives 31:24.
- R4: A read miss drops `reqReady` from the next cycle. It then holds `memReqValid`=1 and `memReqWrite`=0 with a steady `memAddr` equal to the request tag followed by offset bits 00, until `memRdValid` is seen.
- R5: In the cycle `memRdValid` is 1 during a fetch, `respValid`=1, `respHit`=0 and `respData` is the offset-selected byte of `memRdData`. `reqReady` returns to 1 in the next cycle, and from then on the block hits.
- R6: Blocks with unrelated tags, up to the line count (8 by default), are all resident together and all hit.
- R7: With every line full, each miss replaces the block filled earliest. The choice wraps around, so a second round of misses again replaces blocks in the order they were filled.
- R8: Hits do not change the replacement order. A block that is hit often is still the one evicted when it is the oldest.
- R9: A write accepted while `reqReady` is 1 drives `memReqValid`=1, `memReqWrite`=1, `memAddr`=`reqAddr` and `memWdata`=`reqWdata` in that same cycle. It raises no `respValid`, and `reqReady` stays 1.
- R10: A write that hits replaces only the addressed byte of the cached block. Later read hits return the new byte and the old values of the other three bytes.
- R11: A write that misses installs nothing, so a later read of that block misses.
- R12: No two valid lines ever hold the same tag, so at most one line matches any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 for a byte write, 0 for a byte read |
| reqAddr | input | 24 | Byte address: tag in 23:2, offset in 1:0 |
| reqWdata | input | 8 | Byte to write |
| reqReady | output | 1 | Block can take a request this cycle |
| respValid | output | 1 | Read data valid |
| respHit | output | 1 | Read data came from a resident line |
| respData | output | 8 | Read byte |
| memReqValid | output | 1 | Memory access requested |
| memReqWrite | output | 1 | 1 for a write-through, 0 for a block fetch |
| memAddr | output | 24 | Memory address (block-aligned for fetches) |
| memWdata | output | 8 | Write-through byte |
| memRdValid | input | 1 | Fetched block present on `memRdData` |
| memRdData | input | 32 | Fetched block |

## Verification
The assertions take three things for granted about the inputs:
- Memory completes every write-through in the cycle it is issued.
- Memory answers a fetch only while one is outstanding.
- `memRdData` belongs to the block address on `memAddr`.

The bench's memory model keeps to all three. It ignores writes, raises `memRdValid` for exactly one cycle a fixed two cycles after a fetch appears, and derives the block contents from the fetched tag. The requester drops `reqValid` after each accepted request and issues nothing while a fetch is pending.

// File: rtl/fac_pkg.sv
package fac_pkg;

  // Strobes sent from the control to the datapath.
  typedef struct packed {
    logic captureEn;   // latch the missing address
    logic fillEn;      // install the returned block
    logic writeHitEn;  // patch one byte of the matching line
  } ctlStrobe_t;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } ctlState_t;

endpackage

// File: rtl/fac_datapath.sv
module fac_datapath #(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 2,
  parameter int LINES  = 8
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  fac_pkg::ctlStrobe_t             strobe,
  input  logic [ADDR_W-1:0]               reqAddr,
  input  logic [7:0]                      reqWdata,
  input  logic [(8<<OFF_W)-1:0]           memRdData,
  output logic                            hit,
  output logic [LINES-1:0]                matchVec,
  output logic [7:0]                      rdByte,
  output logic [7:0]                      fillByte,
  output logic [ADDR_W-1:0]               fetchAddr
);
  localparam int TAG_W   = ADDR_W - OFF_W;
  localparam int BYTES   = 1 << OFF_W;
  localparam int BLOCK_W = 8 * BYTES;
  localparam int IDX_W   = (LINES > 1) ? $clog2(LINES) : 1;

  logic [LINES-1:0]   lineValid;
  logic [TAG_W-1:0]   lineTag  [LINES];
  logic [BLOCK_W-1:0] lineData [LINES];

  logic [TAG_W-1:0]   reqTag;
  logic [OFF_W-1:0]   reqOff;
  logic [TAG_W-1:0]   pendTag;
  logic [OFF_W-1:0]   pendOff;

  logic [IDX_W-1:0]   hitIdx;
  logic [IDX_W-1:0]   freeIdx;
  logic               anyFree;
  logic [IDX_W-1:0]   fifoPtr;
  logic [IDX_W-1:0]   victimIdx;
  logic [BLOCK_W-1:0] hitBlock;

  assign reqTag = reqAddr[ADDR_W-1:OFF_W];
  assign reqOff = reqAddr[OFF_W-1:0];

  // Compare the request tag with every line at once.
  always_comb begin
    for (int i = 0; i < LINES; i++) begin
      matchVec[i] = lineValid[i] && (lineTag[i] == reqTag);
    end
  end

  assign hit = |matchVec;

  // Lowest-numbered match wins.
  always_comb begin
    hitIdx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (matchVec[i]) hitIdx = IDX_W'(i);
    end
  end

  // Lowest-numbered empty line.
  always_comb begin
    freeIdx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (!lineValid[i]) freeIdx = IDX_W'(i);
    end
  end

  assign anyFree   = ~&lineValid;
  assign victimIdx = anyFree ? freeIdx : fifoPtr;

  assign hitBlock  = lineData[hitIdx];
  assign rdByte    = hitBlock[reqOff*8 +: 8];
  assign fillByte  = memRdData[pendOff*8 +: 8];
  assign fetchAddr = {pendTag, {OFF_W{1'b0}}};

  // Address of the outstanding miss.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendTag <= '0;
      pendOff <= '0;
    end else if (strobe.captureEn) begin
      pendTag <= reqTag;
      pendOff <= reqOff;
    end
  end

  // The pointer moves only when a full cache gives up a line.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoPtr <= '0;
    end else if (strobe.fillEn && !anyFree) begin
      if (fifoPtr == IDX_W'(LINES - 1)) fifoPtr <= '0;
      else                              fifoPtr <= fifoPtr + 1'b1;
    end
  end

  // Line storage, one slice per line.
  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic fillThis;
    logic patchThis;

    assign fillThis  = strobe.fillEn && (victimIdx == IDX_W'(g));
    assign patchThis = strobe.writeHitEn && matchVec[g] && (hitIdx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lineValid[g] <= 1'b0;
      end else if (fillThis) begin
        lineValid[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lineTag[g] <= '0;
      end else if (fillThis) begin
        lineTag[g] <= pendTag;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lineData[g] <= '0;
      end else if (fillThis) begin
        lineData[g] <= memRdData;
      end else if (patchThis) begin
        for (int b = 0; b < BYTES; b++) begin
          if (reqOff == OFF_W'(b)) lineData[g][b*8 +: 8] <= reqWdata;
        end
      end
    end
  end

endmodule

// File: rtl/fac_control.sv
module fac_control (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic                 hit,
  input  logic                 memRdValid,
  output fac_pkg::ctlStrobe_t  strobe,
  output logic                 fetching,
  output logic                 reqReady,
  output logic                 respValid,
  output logic                 respHit,
  output logic                 memReqValid,
  output logic                 memReqWrite
);
  import fac_pkg::*;

  ctlState_t state;
  ctlState_t stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext   = state;
    strobe      = '0;
    reqReady    = 1'b0;
    respValid   = 1'b0;
    respHit     = 1'b0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    fetching    = (state == ST_FETCH);

    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          if (reqWrite) begin
            memReqValid       = 1'b1;
            memReqWrite       = 1'b1;
            strobe.writeHitEn = hit;
          end else if (hit) begin
            respValid = 1'b1;
            respHit   = 1'b1;
          end else begin
            strobe.captureEn = 1'b1;
            stateNext        = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        memReqValid = 1'b1;
        if (memRdValid) begin
          strobe.fillEn = 1'b1;
          respValid     = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/fac_cache.sv
module fac_cache #(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 2,
  parameter int LINES  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [7:0]            reqWdata,
  output logic                  reqReady,
  output logic                  respValid,
  output logic                  respHit,
  output logic [7:0]            respData,
  output logic                  memReqValid,
  output logic                  memReqWrite,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [7:0]            memWdata,
  input  logic                  memRdValid,
  input  logic [(8<<OFF_W)-1:0] memRdData
);
  fac_pkg::ctlStrobe_t strobe;
  logic                hit;
  logic                fetching;
  logic [LINES-1:0]    matchVec;
  logic [7:0]          rdByte;
  logic [7:0]          fillByte;
  logic [ADDR_W-1:0]   fetchAddr;

  fac_control uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .hit        (hit),
    .memRdValid (memRdValid),
    .strobe     (strobe),
    .fetching   (fetching),
    .reqReady   (reqReady),
    .respValid  (respValid),
    .respHit    (respHit),
    .memReqValid(memReqValid),
    .memReqWrite(memReqWrite)
  );

  fac_datapath #(
    .ADDR_W(ADDR_W),
    .OFF_W (OFF_W),
    .LINES (LINES)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .memRdData(memRdData),
    .hit      (hit),
    .matchVec (matchVec),
    .rdByte   (rdByte),
    .fillByte (fillByte),
    .fetchAddr(fetchAddr)
  );

  assign respData = fetching ? fillByte : rdByte;
  assign memAddr  = fetching ? fetchAddr : reqAddr;
  assign memWdata = reqWdata;

endmodule

// File: rtl/fac_cache_chk.sv
module fac_cache_chk #(
  parameter int ADDR_W = 24,
  parameter int LINES  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqReady,
  input logic              respValid,
  input logic              respHit,
  input logic              memReqValid,
  input logic              memReqWrite,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRdValid,
  input logic [LINES-1:0]  matchVec
);

  // R12
  single_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));

  // R2
  hit_quiet_mem_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respHit) |-> !memReqValid);

  // R4
  fetch_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqWrite) |-> (memAddr[1:0] == 2'b00 && !reqReady));

  // R4
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqWrite && !memRdValid) |=>
      (memReqValid && !memReqWrite && $stable(memAddr)));

  // R5
  fill_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqWrite && memRdValid) |-> (respValid && !respHit));

  // R5
  fill_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqWrite && memRdValid) |=> reqReady);

  // R9
  write_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite) |->
      (memReqValid && memReqWrite && memAddr == reqAddr && !respValid));

endmodule

bind fac_cache fac_cache_chk #(.ADDR_W(ADDR_W), .LINES(LINES)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqWrite   (reqWrite),
  .reqAddr    (reqAddr),
  .reqReady   (reqReady),
  .respValid  (respValid),
  .respHit    (respHit),
  .memReqValid(memReqValid),
  .memReqWrite(memReqWrite),
  .memAddr    (memAddr),
  .memRdValid (memRdValid),
  .matchVec   (matchVec)
);

// File: tb/tb_fac_cache.sv
module tb_fac_cache;
  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic        reqWrite;
  logic [23:0] reqAddr;
  logic [7:0]  reqWdata;
  logic        reqReady;
  logic        respValid;
  logic        respHit;
  logic [7:0]  respData;
  logic        memReqValid;
  logic        memReqWrite;
  logic [23:0] memAddr;
  logic [7:0]  memWdata;
  logic        memRdValid;
  logic [31:0] memRdData;

  int vectors    = 0;
  int miscompares = 0;
  int lat;

  always #10 clk = ~clk;

  fac_cache dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .respValid(respValid), .respHit(respHit), .respData(respData),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memRdValid(memRdValid), .memRdData(memRdData)
  );

  function automatic logic [31:0] blockVal(input logic [21:0] tag);
    return ({10'd0, tag} * 32'h2F0B_4C1D) ^ 32'hC0DE_5A5A;
  endfunction

  function automatic logic [7:0] pickByte(input logic [31:0] blk, input logic [1:0] off);
    return blk[off*8 +: 8];
  endfunction

  function automatic logic [21:0] tagOf(input int k);
    return 22'(k * 32'h1F3A7 + 32'h2A5C3);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Memory model: answers a fetch two cycles after it appears.
  initial begin
    memRdValid = 1'b0;
    memRdData  = '0;
    lat        = 0;
    forever begin
      @(negedge clk);
      if (memRdValid) begin
        memRdValid = 1'b0;
        lat        = 0;
      end else if (rstN && memReqValid && !memReqWrite) begin
        lat++;
        if (lat == 2) begin
          memRdValid = 1'b1;
          memRdData  = blockVal(memAddr[23:2]);
        end
      end
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqWdata = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // Read with explicit expected byte; returns through checks only.
  task automatic readExp(input logic [23:0] addr, input bit expHit,
                         input logic [7:0] expByte, input string req);
    bit          gotHit;
    bit          gotResp;
    logic [7:0]  gotData;
    int          waitCnt;
    bit          addrChecked;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = addr;
    #2;
    gotHit  = respValid && respHit;
    gotData = respData;
    if (gotHit) chk(!memReqValid, {req, " hit without memory access"}, 32'(memReqValid), 0);
    @(posedge clk);
    #1 reqValid = 1'b0;
    chk(gotHit == expHit, {req, " hit flag"}, 32'(gotHit), 32'(expHit));
    if (!gotHit) begin
      gotResp = 1'b0;
      waitCnt = 0;
      addrChecked = 1'b0;
      while (!gotResp && waitCnt < 20) begin
        @(negedge clk);
        #2;
        waitCnt++;
        if (!addrChecked && memReqValid) begin
          addrChecked = 1'b1;
          // R4: block-aligned fetch, stalled requester
          chk(!memReqWrite && memAddr == {addr[23:2], 2'b00} && !reqReady,
              "R4 fetch address/stall", 32'(memAddr), 32'({addr[23:2], 2'b00}));
        end
        if (respValid) begin
          gotResp = 1'b1;
          gotData = respData;
          chk(!respHit, "R5 fill response not a hit", 32'(respHit), 0);
        end
      end
      chk(addrChecked, "R4 fetch issued", 32'(addrChecked), 1);
      chk(gotResp, "R5 fill response arrived", 32'(gotResp), 1);
      @(posedge clk);
      @(negedge clk);
      #2;
      chk(reqReady, "R5 ready after fill", 32'(reqReady), 1);
    end
    chk(gotData == expByte, {req, " data"}, 32'(gotData), 32'(expByte));
  endtask

  task automatic readMem(input logic [23:0] addr, input bit expHit, input string req);
    readExp(addr, expHit, pickByte(blockVal(addr[23:2]), addr[1:0]), req);
  endtask

  task automatic writeOp(input logic [23:0] addr, input logic [7:0] data);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = addr; reqWdata = data;
    #2;
    chk(memReqValid && memReqWrite && memAddr == addr && memWdata == data && !respValid,
        "R9 write-through", {memReqValid, memReqWrite, respValid, 5'd0, memAddr},
        {8'hC0, addr});
    @(posedge clk);
    #1 reqValid = 1'b0; reqWrite = 1'b0;
    @(negedge clk);
    #2;
    chk(reqReady, "R9 ready after write", 32'(reqReady), 1);
  endtask

  task automatic testReset();
    doReset();
    #2;
    chk(reqReady && !respValid && !memReqValid, "R1 reset outputs",
        {29'd0, reqReady, respValid, memReqValid}, 32'h4);
    readMem({tagOf(0), 2'd1}, 1'b0, "R1 first read misses");
  endtask

  task automatic testByteSelect();
    doReset();
    readMem({tagOf(3), 2'd2}, 1'b0, "R5 miss byte");
    for (int o = 0; o < 4; o++) begin
      readMem({tagOf(3), 2'(o)}, 1'b1, "R3 R2 byte select hit");
    end
  endtask

  task automatic testAnyLine();
    doReset();
    for (int k = 0; k < 8; k++) readMem({tagOf(k), 2'(k)}, 1'b0, "R6 fill");
    for (int k = 0; k < 8; k++) readMem({tagOf(k), 2'(k + 1)}, 1'b1, "R6 all resident");
  endtask

  task automatic testFifoOrder();
    doReset();
    for (int k = 0; k < 8; k++) readMem({tagOf(k), 2'd0}, 1'b0, "R7 fill");
    // Second round: each new block replaces the oldest one.
    for (int k = 8; k < 16; k++) begin
      readMem({tagOf(k), 2'd0}, 1'b0, "R7 eviction miss");
      for (int j = k - 6; j <= k; j++) readMem({tagOf(j), 2'd3}, 1'b1, "R7 survivors hit");
    end
    readMem({tagOf(0), 2'd0}, 1'b0, "R7 oldest was evicted");
    readMem({tagOf(9), 2'd0}, 1'b1, "R7 wrap keeps next");
  endtask

  task automatic testNotLru();
    doReset();
    for (int k = 0; k < 8; k++) readMem({tagOf(k), 2'd1}, 1'b0, "R8 fill");
    for (int n = 0; n < 3; n++) readMem({tagOf(0), 2'd2}, 1'b1, "R8 hits on oldest");
    readMem({tagOf(20), 2'd0}, 1'b0, "R8 new block");
    readMem({tagOf(1), 2'd0}, 1'b1, "R8 second oldest kept");
    readMem({tagOf(0), 2'd0}, 1'b0, "R8 oldest evicted despite hits");
  endtask

  task automatic testWrite();
    logic [31:0] blk;
    doReset();
    blk = blockVal(tagOf(5));
    readMem({tagOf(5), 2'd0}, 1'b0, "R10 load");
    writeOp({tagOf(5), 2'd2}, 8'h5E);
    for (int o = 0; o < 4; o++) begin
      readExp({tagOf(5), 2'(o)}, 1'b1, (o == 2) ? 8'h5E : pickByte(blk, 2'(o)),
              "R10 patched block");
    end
    writeOp({tagOf(6), 2'd1}, 8'hA7);
    readMem({tagOf(6), 2'd1}, 1'b0, "R11 write miss not allocated");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqWdata = '0;
    testReset();
    testByteSelect();
    testAnyLine();
    testFifoOrder();
    testNotLru();
    testWrite();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule